// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a multiply-accumulate engine with a single accumulator. Each accepted command multiplies two operands. The product is then added to the accumulator, subtracted from it, or returned on its own without touching the accumulator. A separate command loads the accumulator with a value. A small mode register sets four things: whether operands are integers or signed fixed-point fractions, whether integers are signed or unsigned, whether an out-of-range result is clamped, and whether a fractional product is rounded to nearest even or truncated before it is accumulated.

The accumulator is 40 bits wide for the default 32-bit operands. Its upper 32 bits are the visible value: an integer, or a Q1.31 fraction. The lower 8 bits are extra fraction bits that only fractional products fill. Any result outside the accumulator's range sets a sticky overflow flag. When clamping is on, the accumulator takes a limit value. It then ignores further accumulate commands until software writes the mode register with the overflow bit cleared, or loads the accumulator. Negative and zero flags follow each accumulate or load result.

A mode-register write and a command handshake share one cycle slot. During a write the unit drops its ready output, so a pending command is taken on the next cycle under the new mode.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset the accumulator (acc_o and acc_guard_o), mul_o, all three flags, the mode and out_valid are zero, and in_ready is high.
- R2: in_ready is low exactly in the cycles where cfg_we is high. A command is taken when in_valid and in_ready are both high. out_valid is high for one cycle, the cycle after each taken command, and for no other cycle.
- R3: In integer mode (cfg bit 1 = 0), opcode 1 (MAC) adds a×b to the accumulator and opcode 2 (MSAC) subtracts it. The operands are unsigned when cfg bit 2 = 1 and two's complement otherwise. The integer result appears on acc_o.
- R4: In fractional mode (cfg bit 1 = 1), the operands are signed Q1.31 values. The product is doubled and aligned so that its top bits land on acc_o and the next 8 bits land on acc_guard_o. With cfg bit 0 = 0, the remaining 24 product bits are dropped.
- R5: With cfg bit 0 = 1 in fractional mode, the 24 dropped bits round the aligned product. Above half rounds up. Below half rounds down. Exactly half rounds to the even value.
- R6: A MAC or MSAC whose exact result lies outside the accumulator's range sets flag_v. flag_v then stays set until a mode write. Without clamping, the accumulator keeps the low 40 bits of the exact result.
- R7: With clamping on (cfg bit 3 = 1) in signed or fractional mode, an overflow gives acc_o = 0x7FFF_FFFF for a too-large result and 0x8000_0000 for a too-small one, with acc_guard_o = 0.
- R8: With clamping on in unsigned integer mode, an overflow gives acc_o = 0xFFFF_FFFF for a too-large result and 0x0000_0000 for a negative one.
- R9: After a clamped overflow, MAC and MSAC change neither the accumulator nor the flags. This lasts until a LOAD, or until a mode write with bit 4 = 0.
- R10: MAC, MSAC and LOAD set flag_n to the accumulator msb and set flag_z when all 40 bits are zero. Opcode 4 (MUL) puts the low 32 product bits (integer) or the aligned fraction (fractional) on mul_o, and leaves the accumulator and the flags untouched.
- R11: Opcode 3 (LOAD) sets acc_o = in_a and acc_guard_o = 0, and leaves flag_v unchanged.
- R12: Opcodes 0, 5, 6 and 7 change neither the accumulator, the flags nor mul_o.
- R13: A write with cfg_we high loads the mode bits cfg_wdata[3:0] (bit 0 round, bit 1 fraction, bit 2 unsigned, bit 3 clamp) and copies cfg_wdata[4] into flag_v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 5 | Mode bits [3:0] and overflow bit [4] |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be taken this cycle |
| in_op | input | 3 | Opcode: 1 MAC, 2 MSAC, 3 LOAD, 4 MUL |
| in_a | input | OP_W | First operand or load value |
| in_b | input | OP_W | Second operand |
| out_valid | output | 1 | One-cycle pulse after a taken command |
| acc_o | output | OP_W | Accumulator, visible part |
| acc_guard_o | output | GRD_W | Accumulator, extra fraction bits |
| mul_o | output | OP_W | Result of the last MUL |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sticky overflow flag |

## Verification
A mode write and a waiting command can arrive in the same cycle. The bench provokes this by raising cfg_we while in_valid holds a fractional MAC whose result differs greatly between the old integer mode and the new fractional mode. It then judges three things: in_ready is low in the write cycle, exactly one result is produced, and that result is the fractional one. A second overlap is a clamped overflow followed by further accumulates. The bench checks that the frozen value survives them, and that a LOAD or a clearing write releases it.

// File: rtl/mac_pkg.sv
package mac_pkg;

   localparam int OPC_W = 3;
   localparam int CFG_W = 5;
   localparam int CFG_OVF_BIT = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP  = 3'd0,
      OPC_MAC  = 3'd1,
      OPC_MSAC = 3'd2,
      OPC_LOAD = 3'd3,
      OPC_MUL  = 3'd4
   } mac_opc_e;

   // packed order sets the bit positions: clamp [3], unsigned [2], fraction [1], round [0]
   typedef struct packed {
      logic clamp;
      logic unsgn;
      logic fract;
      logic rnd;
   } mac_mode_t;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OP_W  = 32,
   parameter int GRD_W = 8,
   parameter int TRM_W = 2*OP_W + GRD_W + 2
)(
   input  logic [OP_W-1:0]         a_i,
   input  logic [OP_W-1:0]         b_i,
   input  logic                    unsgn_i,
   input  logic                    fract_i,
   input  logic                    rnd_i,
   output logic signed [TRM_W-1:0] term_o,
   output logic [OP_W-1:0]         mul_o
);

   localparam int PW    = 2*OP_W + 2;
   localparam int RND_W = OP_W - GRD_W;
   localparam int UP_W  = PW - RND_W;
   localparam logic [RND_W-1:0] HALF = RND_W'(1) << (RND_W-1);

   logic                   zext;
   logic signed [OP_W:0]   ax, bx;
   logic signed [PW-1:0]   ax_w, bx_w, prod, p2;
   logic signed [UP_W-1:0] upper;
   logic [RND_W-1:0]       lowbits;
   logic                   inc;
   logic signed [TRM_W-1:0] iterm, fterm;

   // one signed (OP_W+1)-bit multiplier serves signed and unsigned integers and fractions
   always_comb begin
      zext  = unsgn_i & ~fract_i;
      ax    = zext ? {1'b0, a_i} : {a_i[OP_W-1], a_i};
      bx    = zext ? {1'b0, b_i} : {b_i[OP_W-1], b_i};
      ax_w  = PW'(ax);
      bx_w  = PW'(bx);
      prod  = ax_w * bx_w;
   end

   // fraction: double the product, keep ACC_W fraction bits, round on the rest
   always_comb begin
      p2      = prod <<< 1;
      upper   = p2[PW-1:RND_W];
      lowbits = p2[RND_W-1:0];
      inc     = rnd_i & ((lowbits > HALF) | ((lowbits == HALF) & upper[0]));
      fterm   = TRM_W'(upper) + TRM_W'(inc);
      iterm   = TRM_W'(prod) <<< GRD_W;
   end

   assign term_o = fract_i ? fterm : iterm;
   assign mul_o  = fract_i ? fterm[GRD_W +: OP_W] : prod[OP_W-1:0];

endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
   parameter int OP_W  = 32,
   parameter int GRD_W = 8,
   parameter int TRM_W = 2*OP_W + GRD_W + 2
)(
   input  logic [OP_W+GRD_W-1:0]   acc_i,
   input  logic signed [TRM_W-1:0] term_i,
   input  logic                    sub_i,
   input  logic                    unsgn_i,
   input  logic                    clamp_i,
   output logic [OP_W+GRD_W-1:0]   res_o,
   output logic                    ovf_o
);

   localparam int ACC_W = OP_W + GRD_W;
   localparam int SW    = TRM_W + 1;
   localparam logic [ACC_W-1:0] LIM_SMAX = ACC_W'({1'b0, {(OP_W-1){1'b1}}}) << GRD_W;
   localparam logic [ACC_W-1:0] LIM_SMIN = ACC_W'(1) << (ACC_W-1);
   localparam logic [ACC_W-1:0] LIM_UMAX = ACC_W'({OP_W{1'b1}}) << GRD_W;

   logic signed [SW-1:0] accx, termx, sum;
   logic fits_s, fits_u, neg;
   logic [ACC_W-1:0] limit;

   always_comb begin
      accx   = unsgn_i ? SW'(acc_i) : SW'($signed(acc_i));
      termx  = SW'(term_i);
      sum    = sub_i ? (accx - termx) : (accx + termx);
      fits_s = (sum[SW-1:ACC_W-1] == '0) | (sum[SW-1:ACC_W-1] == '1);
      fits_u = (sum[SW-1:ACC_W] == '0);
      ovf_o  = unsgn_i ? ~fits_u : ~fits_s;
      neg    = sum[SW-1];
      if (unsgn_i) limit = neg ? '0 : LIM_UMAX;
      else         limit = neg ? LIM_SMIN : LIM_SMAX;
      res_o  = (ovf_o & clamp_i) ? limit : sum[ACC_W-1:0];
   end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
   import mac_pkg::*;
#(
   parameter int OP_W  = 32,
   parameter int GRD_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OPC_W-1:0] in_op,
   input  logic [OP_W-1:0]  in_a,
   input  logic [OP_W-1:0]  in_b,
   output logic             out_valid,
   output logic [OP_W-1:0]  acc_o,
   output logic [GRD_W-1:0] acc_guard_o,
   output logic [OP_W-1:0]  mul_o,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v
);

   localparam int ACC_W = OP_W + GRD_W;
   localparam int TRM_W = 2*OP_W + GRD_W + 2;
   localparam logic [ACC_W-1:0] CHK_SMAX = ACC_W'({1'b0, {(OP_W-1){1'b1}}}) << GRD_W;
   localparam logic [ACC_W-1:0] CHK_SMIN = ACC_W'(1) << (ACC_W-1);
   localparam logic [ACC_W-1:0] CHK_UMAX = ACC_W'({OP_W{1'b1}}) << GRD_W;

   if (OP_W < 4) begin : g_bad_opw
      $error("mac_sat_unit: OP_W must be at least 4");
   end
   if (GRD_W < 1 || GRD_W >= OP_W) begin : g_bad_grd
      $error("mac_sat_unit: GRD_W must lie in 1..OP_W-1");
   end

   mac_mode_t        mode_q;
   logic             ovf_q, hold_q, n_q, z_q, vld_q;
   logic [ACC_W-1:0] acc_q;
   logic [OP_W-1:0]  mul_q;

   mac_opc_e         opc;
   logic             fire, acc_cmd;
   logic signed [TRM_W-1:0] term_w;
   logic [OP_W-1:0]  mul_w;
   logic [ACC_W-1:0] sum_res, load_val;
   logic             sum_ovf;

   assign in_ready = ~cfg_we;
   assign fire     = in_valid & in_ready;
   assign opc      = mac_opc_e'(in_op);
   assign acc_cmd  = fire & ((opc == OPC_MAC) | (opc == OPC_MSAC));
   assign load_val = ACC_W'(in_a) << GRD_W;

   mac_mult #(.OP_W(OP_W), .GRD_W(GRD_W), .TRM_W(TRM_W)) u_mult (
      .a_i     (in_a),
      .b_i     (in_b),
      .unsgn_i (mode_q.unsgn),
      .fract_i (mode_q.fract),
      .rnd_i   (mode_q.rnd),
      .term_o  (term_w),
      .mul_o   (mul_w)
   );

   mac_addsat #(.OP_W(OP_W), .GRD_W(GRD_W), .TRM_W(TRM_W)) u_addsat (
      .acc_i   (acc_q),
      .term_i  (term_w),
      .sub_i   (opc == OPC_MSAC),
      .unsgn_i (mode_q.unsgn & ~mode_q.fract),
      .clamp_i (mode_q.clamp),
      .res_o   (sum_res),
      .ovf_o   (sum_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ovf_q  <= 1'b0;
         hold_q <= 1'b0;
         n_q    <= 1'b0;
         z_q    <= 1'b0;
         vld_q  <= 1'b0;
         acc_q  <= '0;
         mul_q  <= '0;
      end else begin
         vld_q <= fire;
         if (cfg_we) begin
            mode_q <= mac_mode_t'(cfg_wdata[3:0]);
            ovf_q  <= cfg_wdata[CFG_OVF_BIT];
            if (!cfg_wdata[CFG_OVF_BIT]) hold_q <= 1'b0;
         end else if (fire) begin
            case (opc)
               OPC_MAC, OPC_MSAC: begin
                  if (!hold_q) begin
                     acc_q <= sum_res;
                     n_q   <= sum_res[ACC_W-1];
                     z_q   <= (sum_res == '0);
                     if (sum_ovf) begin
                        ovf_q <= 1'b1;
                        if (mode_q.clamp) hold_q <= 1'b1;
                     end
                  end
               end
               OPC_LOAD: begin
                  acc_q  <= load_val;
                  n_q    <= in_a[OP_W-1];
                  z_q    <= (in_a == '0);
                  hold_q <= 1'b0;
               end
               OPC_MUL: mul_q <= mul_w;
               default: ;
            endcase
         end
      end
   end

   assign out_valid   = vld_q;
   assign acc_o       = acc_q[ACC_W-1:GRD_W];
   assign acc_guard_o = acc_q[GRD_W-1:0];
   assign mul_o       = mul_q;
   assign flag_n      = n_q;
   assign flag_z      = z_q;
   assign flag_v      = ovf_q;

   // R2
   accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);
   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !out_valid);
   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !cfg_we) |=> ovf_q);
   // R9
   frozen_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cmd && hold_q) |=> ($stable(acc_q) && $stable(n_q) && $stable(z_q)));
   // R10
   mul_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && opc == OPC_MUL) |=> ($stable(acc_q) && $stable(n_q) && $stable(z_q)));
   // R11
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && opc == OPC_LOAD) |=> (acc_o == $past(in_a) && acc_guard_o == '0));
   // R7 R8
   clamp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cmd && !hold_q && mode_q.clamp && sum_ovf) |=>
      (acc_q == CHK_SMAX || acc_q == CHK_SMIN || acc_q == CHK_UMAX || acc_q == '0));

endmodule

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [2:0]  in_op = '0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        out_valid;
   logic [31:0] acc_o;
   logic [7:0]  acc_guard_o;
   logic [31:0] mul_o;
   logic        flag_n, flag_z, flag_v;

   always #10 clk = ~clk;

   mac_sat_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .acc_o(acc_o), .acc_guard_o(acc_guard_o), .mul_o(mul_o),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
   );

   localparam logic [2:0] K_MAC = 3'd1, K_MSAC = 3'd2, K_LOAD = 3'd3, K_MUL = 3'd4;
   // mode words: [4] overflow, [3] clamp, [2] unsigned, [1] fraction, [0] round
   localparam logic [4:0] W_INT = 5'b00000, W_SAT = 5'b01000, W_USAT = 5'b01100,
                          W_FRC = 5'b00010, W_FRND = 5'b00011, W_FSAT = 5'b01010;

   typedef struct {
      logic [31:0] acc;
      logic [7:0]  grd;
      logic        n, z, v;
      logic [31:0] mul;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   exp_t        mon_e;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] exp_mul = '0;

   task automatic check(string tag, logic [74:0] act, logic [74:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop one expected item per result pulse
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 extra out_valid actual=1 expected=0");
         end else begin
            mon_e = sb_q.pop_front();
            check(mon_e.tag,
                  {acc_o, acc_guard_o, flag_n, flag_z, flag_v, mul_o},
                  {mon_e.acc, mon_e.grd, mon_e.n, mon_e.z, mon_e.v, mon_e.mul});
         end
      end
   end

   task automatic send(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic [31:0] acc, logic [7:0] g, logic n, logic z, logic v, string tag);
      exp_t e;
      @(negedge clk);
      in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
      e = '{acc, g, n, z, v, exp_mul, tag};
      sb_q.push_back(e);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic cfg(logic [4:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset", {acc_o, acc_guard_o, flag_n, flag_z, flag_v, mul_o}, '0);
      check("R1 ready", {74'd0, in_ready}, {74'd0, 1'b1});
      check("R1 out_valid", {74'd0, out_valid}, '0);

      // R3 R10 R11 R12 signed integer
      cfg(W_INT);
      send(K_LOAD, 32'd5, 32'd0, 32'd5, 8'h00, 0, 0, 0, "R11 load");
      send(K_MAC, 32'd3, 32'd4, 32'd17, 8'h00, 0, 0, 0, "R3 mac");
      send(K_MSAC, 32'd10, 32'd2, 32'hFFFF_FFFD, 8'h00, 1, 0, 0, "R3 msac negative");
      exp_mul = 32'hFFFF_FFF2;
      send(K_MUL, 32'hFFFF_FFFE, 32'd7, 32'hFFFF_FFFD, 8'h00, 1, 0, 0, "R10 mul keeps flags");
      send(K_MAC, 32'd1, 32'd3, 32'd0, 8'h00, 0, 1, 0, "R10 zero flag");
      send(3'd7, 32'd9, 32'd9, 32'd0, 8'h00, 0, 1, 0, "R12 undefined opcode");

      // R6 overflow without clamping wraps and sticks
      send(K_LOAD, 32'h7FFF_FFFF, 32'd0, 32'h7FFF_FFFF, 8'h00, 0, 0, 0, "R11 load max");
      send(K_MAC, 32'd1, 32'd1, 32'h8000_0000, 8'h00, 1, 0, 1, "R6 wrap");
      send(K_MAC, 32'd1, 32'd1, 32'h8000_0001, 8'h00, 1, 0, 1, "R6 sticky");

      // R13 write clears overflow
      cfg(W_SAT);
      check("R13 flag_v cleared", {74'd0, flag_v}, '0);

      // R7 R9 signed clamping and freeze
      send(K_LOAD, 32'h7FFF_FFF0, 32'd0, 32'h7FFF_FFF0, 8'h00, 0, 0, 0, "R11 load");
      send(K_MAC, 32'h10, 32'h10, 32'h7FFF_FFFF, 8'h00, 0, 0, 1, "R7 clamp high");
      send(K_MSAC, 32'd1, 32'd1000, 32'h7FFF_FFFF, 8'h00, 0, 0, 1, "R9 frozen");
      send(K_LOAD, 32'd0, 32'd0, 32'd0, 8'h00, 0, 1, 1, "R11 load keeps v");
      send(K_MSAC, 32'd1, 32'd1, 32'hFFFF_FFFF, 8'h00, 1, 0, 1, "R9 released by load");
      send(K_LOAD, 32'h8000_0005, 32'd0, 32'h8000_0005, 8'h00, 1, 0, 1, "R11 load");
      send(K_MSAC, 32'd2, 32'd8, 32'h8000_0000, 8'h00, 1, 0, 1, "R7 clamp low");
      cfg(W_SAT);
      send(K_MAC, 32'd1, 32'd1, 32'h8000_0001, 8'h00, 1, 0, 0, "R9 released by write");

      // R8 unsigned clamping
      cfg(W_USAT);
      send(K_LOAD, 32'hFFFF_FFF0, 32'd0, 32'hFFFF_FFF0, 8'h00, 1, 0, 0, "R11 load");
      send(K_MAC, 32'h20, 32'd1, 32'hFFFF_FFFF, 8'h00, 1, 0, 1, "R8 clamp high");
      cfg(W_USAT);
      send(K_LOAD, 32'd5, 32'd0, 32'd5, 8'h00, 0, 0, 0, "R11 load");
      send(K_MSAC, 32'd2, 32'd3, 32'd0, 8'h00, 0, 1, 1, "R8 clamp zero");

      // R4 R5 fractional alignment and rounding
      cfg(W_FRC);
      send(K_LOAD, 32'd0, 32'd0, 32'd0, 8'h00, 0, 1, 0, "R11 load zero");
      send(K_MAC, 32'h4000_0000, 32'h4000_0000, 32'h2000_0000, 8'h00, 0, 0, 0, "R4 half times half");
      send(K_MAC, 32'h00C0_0000, 32'd1, 32'h2000_0000, 8'h01, 0, 0, 0, "R4 truncate");
      cfg(W_FRND);
      send(K_MAC, 32'h00C0_0000, 32'd1, 32'h2000_0000, 8'h03, 0, 0, 0, "R5 tie to even up");
      send(K_MAC, 32'h0040_0000, 32'd1, 32'h2000_0000, 8'h03, 0, 0, 0, "R5 tie to even down");
      send(K_MAC, 32'h0040_0001, 32'd1, 32'h2000_0000, 8'h04, 0, 0, 0, "R5 above half");
      exp_mul = 32'h2000_0000;
      send(K_MUL, 32'h4000_0000, 32'h4000_0000, 32'h2000_0000, 8'h04, 0, 0, 0, "R10 fractional mul");

      // R7 fractional clamping of -1 * -1
      cfg(W_FSAT);
      send(K_LOAD, 32'd0, 32'd0, 32'd0, 8'h00, 0, 1, 0, "R11 load zero");
      send(K_MAC, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 8'h00, 0, 0, 1, "R7 fraction clamp");

      // R2 R13 mode write in the same cycle as a waiting command
      cfg(W_INT);
      send(K_LOAD, 32'd0, 32'd0, 32'd0, 8'h00, 0, 1, 0, "R11 load zero");
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = W_FRC;
      in_op = K_MAC; in_a = 32'h4000_0000; in_b = 32'h4000_0000; in_valid = 1'b1;
      sb_q.push_back('{32'h2000_0000, 8'h00, 1'b0, 1'b0, 1'b0, exp_mul, "R13 op after write uses new mode"});
      #1;
      check("R2 ready low during write", {74'd0, in_ready}, '0);
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;

      repeat (4) @(negedge clk);
      check("R2 all results produced", 75'(sb_q.size()), '0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule